// File: doc/BRIEF.md
# Binary32 Divider with Round-to-Nearest-Even

This block divides one normalized single-precision floating-point number by another and returns the quotient rounded to nearest, ties to even. A caller presents two 32-bit operands with a one-cycle `start` strobe. The block then works for a fixed number of cycles and raises `done` for exactly one cycle while `quotient` holds the packed result.

Inside, a restoring divider produces one quotient bit per cycle from the two 24-bit significands. It produces four bits beyond the significand, so that one left shift for normalization still leaves guard and round positions. The sticky bit is not taken from those extra bits alone. It is the OR of the lowest developed bit and a flag that says the final partial remainder is nonzero, so the rounding sees the whole exact quotient. The result sign is the XOR of the operand signs. The exponent is the difference of the biased exponents plus the bias, lowered by one when normalization shifts.

Only normal operands whose quotient is also normal are in scope. Zeros, subnormals, infinities, NaNs, overflow and underflow are outside this block's contract.

Top module: `fp32_div_rne`

## Requirements
- R1: The sign bit (bit 31) of `quotient` is the XOR of bit 31 of `op_a` and bit 31 of `op_b`.
- R2: When the significand of `op_a` (hidden one and bits 22:0) is not smaller than that of `op_b`, the result exponent field (bits 30:23) equals exp(a) - exp(b) + 127, unless rounding carries.
- R3: When the significand of `op_a` is smaller than that of `op_b`, the quotient is shifted left one place and the exponent field equals exp(a) - exp(b) + 126.
- R4: For any normal operands with a normal quotient, `quotient` equals the exact quotient rounded to nearest, ties to even, in binary32.
- R5: The sticky bit accounts for any nonzero remainder. 0x44216B87 divided by 0x43F69AD5 gives 0x3FA791E1: exponent field 127, fraction 01001111001000111100001.
- R6: Exact quotients come out unrounded: x/1.0 returns x, and x/0.5 returns x with its exponent field raised by one.
- R7: `done` is high for exactly one cycle, 29 rising edges after the edge that samples `start`. `quotient` is valid while `done` is high.
- R8: A `start` that arrives while a division is in progress is ignored. It produces no extra `done`, and the running result is unchanged.
- R9: While `rst_n` is low, `done` is 0 and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| op_a | input | 32 | Dividend, binary32 |
| op_b | input | 32 | Divisor, binary32 |
| quotient | output | 32 | Rounded binary32 quotient |
| done | output | 1 | One-cycle strobe marking `quotient` valid |

## Verification
Normalization and the sticky decision fall in the same cycle. When the leading quotient bit is zero, the one-place shift moves guard and round down by one position. The lowest developed bit then joins the remainder flag in the sticky term. This is provoked by directed pairs with a smaller dividend significand, including the R5 case whose developed bits alone would round the wrong way, and by random pairs in both significand orders. Each result is judged against a wide integer long division in the bench that rounds from the exact remainder.

// File: rtl/fp32_div_rne.sv
module fp32_div_rne #(
  parameter int FRAC_W = 23,
  parameter int EXP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [FRAC_W+EXP_W:0]   op_a,
  input  logic [FRAC_W+EXP_W:0]   op_b,
  output logic [FRAC_W+EXP_W:0]   quotient,
  output logic                    done
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int Q_W   = SIG_W + 4;
  localparam int CNT_W = $clog2(Q_W + 1);
  localparam int XW    = EXP_W + 2;
  localparam int TOP   = FRAC_W + EXP_W;
  localparam logic [XW-1:0] BIAS = XW'((1 << (EXP_W - 1)) - 1);

  logic             busy, fin, sgn_q;
  logic [CNT_W-1:0] cnt;
  logic [XW-1:0]    exp_q;
  logic [SIG_W:0]   rem_q;
  logic [SIG_W-1:0] dvs_q;
  logic [Q_W-1:0]   quo_q;

  // one restoring step
  logic             ge;
  logic [SIG_W:0]   diff, kept;
  assign ge   = rem_q >= {1'b0, dvs_q};
  assign diff = rem_q - {1'b0, dvs_q};
  assign kept = ge ? diff : rem_q;

  // normalize, build guard/round/sticky, round to nearest even
  logic             norm, g, r, s, up;
  logic [SIG_W-1:0] sig_n, sig_f;
  logic [SIG_W:0]   sum;
  logic [XW-1:0]    exp_n, exp_f;
  assign norm  = quo_q[Q_W-1];
  assign sig_n = norm ? quo_q[Q_W-1 -: SIG_W] : quo_q[Q_W-2 -: SIG_W];
  assign g     = norm ? quo_q[3] : quo_q[2];
  assign r     = norm ? quo_q[2] : quo_q[1];
  assign s     = (norm ? |quo_q[1:0] : quo_q[0]) | (rem_q != '0);
  assign exp_n = exp_q - {{(XW-1){1'b0}}, ~norm};
  assign up    = g & (r | s | sig_n[0]);
  assign sum   = {1'b0, sig_n} + {{SIG_W{1'b0}}, up};
  assign sig_f = sum[SIG_W] ? sum[SIG_W:1] : sum[SIG_W-1:0];
  assign exp_f = exp_n + {{(XW-1){1'b0}}, sum[SIG_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fin <= 1'b0; done <= 1'b0; cnt <= '0;
      sgn_q <= 1'b0; exp_q <= '0; rem_q <= '0; dvs_q <= '0; quo_q <= '0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (fin) begin
        fin      <= 1'b0;
        done     <= 1'b1;
        quotient <= {sgn_q, exp_f[EXP_W-1:0], sig_f[FRAC_W-1:0]};
      end else if (busy) begin
        quo_q <= {quo_q[Q_W-2:0], ge};
        rem_q <= {kept[SIG_W-1:0], 1'b0};
        cnt   <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(Q_W);
        sgn_q <= op_a[TOP] ^ op_b[TOP];
        exp_q <= {2'b00, op_a[TOP-1:FRAC_W]} - {2'b00, op_b[TOP-1:FRAC_W]} + BIAS;
        rem_q <= {2'b01, op_a[FRAC_W-1:0]};
        dvs_q <= {1'b1, op_b[FRAC_W-1:0]};
        quo_q <= '0;
      end
    end
  end

  // R4: partial remainder always below twice the divisor
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem_q < {dvs_q, 1'b0});
  // R3: at most one leading zero in the developed quotient
  a_r3_norm_one: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (quo_q[Q_W-1] | quo_q[Q_W-2]));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_fin_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> $past(busy));
  a_r8_divisor_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dvs_q));
endmodule

// File: tb/fp32_div_rne_tb.sv
`timescale 1ns/1ps
module fp32_div_rne_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] quotient;
  logic done;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  int cyc_q[$];
  logic done_prev = 1'b0;

  fp32_div_rne u_dut (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a),
                      .op_b(op_b), .quotient(quotient), .done(done));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ma, mb, q, rm;
    logic [23:0] sig;
    logic [15:0] low;
    int e;
    bit up;
    ma = {40'd0, 1'b1, a[22:0]};
    mb = {40'd0, 1'b1, b[22:0]};
    e  = int'(a[30:23]) - int'(b[30:23]) + 127;
    q  = (ma << 39) / mb;
    rm = (ma << 39) % mb;
    if (!q[39]) begin
      q  = (ma << 40) / mb;
      rm = (ma << 40) % mb;
      e  = e - 1;
    end
    sig = q[39:16];
    low = q[15:0];
    up  = (low > 16'h8000) || (low == 16'h8000 && (rm != 0 || sig[0]));
    if (up) begin
      if (sig == 24'hFFFFFF) begin sig = 24'h800000; e = e + 1; end
      else sig = sig + 1;
    end
    return {a[31] ^ b[31], e[7:0], sig[22:0]};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag); cyc_q.push_back(cyc);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input string tag);
    issue(a, b, ref_div(a, b), tag);
    wait_empty();
  endtask

  // monitor: pops the scoreboard on every done strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (done_prev) check(1'b0, "R7 done wider than one cycle", 32'd1, 32'd0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", quotient, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic int c = cyc_q.pop_front();
        check(quotient == e, t, quotient, e);
        check(cyc - c == 30, "R7 latency", 32'(cyc - c), 32'd30);
      end
    end
    done_prev = done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 done in reset", {31'd0, done}, 32'd0);
    check(quotient == 32'd0, "R9 quotient in reset", quotient, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 sign combinations
    run(32'hC0400000, 32'h40000000, "R1 neg/pos");
    run(32'hC0400000, 32'hC0000000, "R1 neg/neg");
    run(32'h40400000, 32'hBFC00000, "R1 pos/neg");
    // R2 dividend significand not smaller
    run(32'h40C00000, 32'h3FC00000, "R2 6/1.5");
    run(32'h42F6E979, 32'h41200000, "R2 larger sig");
    // R3 dividend significand smaller: normalization shift
    run(32'h3F800000, 32'h3FC00000, "R3 1/1.5");
    run(32'h3F800000, 32'h40400000, "R3 1/3");
    run(32'h3F800000, 32'h3F800001, "R3 1/(1+ulp)");
    // R5 sticky from remainder, constant expectation
    issue(32'h44216B87, 32'h43F69AD5, 32'h3FA791E1, "R5 sticky directed");
    wait_empty();
    // R6 exact quotients
    issue(32'h40490FDB, 32'h3F800000, 32'h40490FDB, "R6 x/1");
    wait_empty();
    issue(32'h40490FDB, 32'h3F000000, 32'h40C90FDB, "R6 x/0.5");
    wait_empty();
    // R8 start during a run is ignored
    issue(32'h41200000, 32'h40400000, ref_div(32'h41200000, 32'h40400000), "R8 ignored start");
    repeat (5) @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F800000; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = '0; op_b = '0;
    wait_empty();
    repeat (40) @(negedge clk);
    // R4 random normal operands
    for (int i = 0; i < 60; i++) begin
      automatic logic [31:0] a, b;
      a = {1'($urandom), 8'(100 + $urandom_range(0, 54)), 23'($urandom)};
      b = {1'($urandom), 8'(100 + $urandom_range(0, 54)), 23'($urandom)};
      run(a, b, "R4 random");
    end
    repeat (5) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule